// File: doc/BRIEF.md
# Clock Status Sticky Flag Controller

This block keeps the status bits that a clock generation module reports to software: a live lock bit, a sticky lock bit that remembers any loss of lock since reset, and a sticky clock-lost bit that remembers any reference or PLL failure. It watches the lock indication from the PLL, loss-of-clock event pulses from a detector, the selected clock mode and a low-power stop handshake. It carries the sticky bits unchanged through stop mode. On a fast wakeup it substitutes temporary values until the PLL relocks or the oscillator restarts.

All flags are registered in the single `clk` domain with a synchronous, active-high reset. A read strobe copies the registered flags into a read register. A read therefore always returns the values from before any event that lands in the same cycle. The PLL, oscillator, loss-of-clock detector and reset source are outside the block.

Top module: `clkstat_flags`

## Requirements
- R1: Reset sets `lock_live` and `clk_lost` to 0. It sets `lock_sticky` to 1 when `clk_mode` is a PLL mode (2'b01 normal, 2'b10 one-to-one, any nonzero code) and to 0 when `clk_mode` is 2'b00 (external clock).
- R2: In a PLL mode, `lock_live` equals `pll_lock_in` one cycle later. In external mode it stays 0.
- R3: While running, when `lock_live` is 1 and `pll_lock_in` is 0, `lock_sticky` becomes 0 on the next cycle. Only reset sets it back to 1.
- R4: While running in a PLL mode, a `loc_pulse` with `loc_enable` high sets `clk_lost` on the next cycle. Once set, it stays set until reset.
- R5: A `loc_pulse` has no effect on `clk_lost` while `loc_enable` is 0 or while `clk_mode` is external.
- R6: A cycle with `stop_req` high enters stop. While stopped, `lock_sticky` and `clk_lost` keep their pre-stop values, and lock drops and loss-of-clock pulses are ignored.
- R7: When `stop_req` falls and fast wakeup was not enabled at stop entry, running resumes with both sticky flags unchanged.
- R8: When `stop_req` falls and `fast_wake_en` was high at stop entry, `lock_sticky` reads 0 from the next cycle. It keeps reading 0 until the cycle after `pll_lock_in` is seen high, and then returns to its pre-stop value.
- R9: On such a fast wakeup, if `stop_cfg` was 2'b11 at stop entry, `clk_lost` reads 1 from the next cycle whatever `loc_enable` is. It returns to its pre-stop value the cycle after `osc_ready` is seen high. For any other `stop_cfg` value, `clk_lost` is left alone.
- R10: A cycle with `rd_strobe` high loads `rd_flags` = {`lock_live`, `lock_sticky`, `clk_lost`} (bit 2, bit 1, bit 0) as registered in that cycle, visible the next cycle. An event in the same cycle is not reflected. `rd_flags` holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_mode | input | 2 | 00 external, 01 normal PLL, 10 one-to-one PLL |
| pll_lock_in | input | 1 | Instantaneous PLL lock indication |
| loc_pulse | input | 1 | Loss-of-clock event, one cycle |
| loc_enable | input | 1 | Enables loss-of-clock capture while running |
| stop_req | input | 1 | Stop request, level |
| stop_cfg | input | 2 | Stop kind; 11 means PLL and oscillator both off |
| fast_wake_en | input | 1 | Fast wakeup enable, sampled at stop entry |
| osc_ready | input | 1 | Oscillator has restarted |
| rd_strobe | input | 1 | Status register read |
| lock_live | output | 1 | Registered lock bit |
| lock_sticky | output | 1 | Sticky lock bit |
| clk_lost | output | 1 | Sticky loss-of-clock bit |
| rd_flags | output | 3 | Value returned by the last read |

## Verification
Every result in this block is due exactly one clock edge after the input that causes it. This covers the live lock copy, the sticky clears and sets, the forced wakeup values, their restoration and the read capture. Stop entry and exit take effect at the edge where `stop_req` is sampled. The bench drives every input on the falling edge and samples the outputs on the next falling edge, half a period after the edge that updates them. Wakeup sequences hold `pll_lock_in` and `osc_ready` low across several samples, so that a forced value is seen to persist before it is released.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;
  localparam int MODE_W = 2;
  localparam int SEL_W  = 2;
  localparam int RD_W   = 3;
  localparam int RD_LIVE_BIT   = 2;
  localparam int RD_STICKY_BIT = 1;
  localparam int RD_LOST_BIT   = 0;
  localparam logic [MODE_W-1:0] MODE_EXTERNAL = '0;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_STOP = 2'd1,
    PH_WAKE = 2'd2
  } phase_e;
endpackage

// File: rtl/clkstat_seq.sv
module clkstat_seq
  import clkstat_pkg::*;
#(
  parameter int                 CFG_W   = SEL_W,
  parameter logic [CFG_W-1:0]   ALL_OFF = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic [CFG_W-1:0] stop_cfg,
  input  logic             fast_wake_en,
  input  logic             pll_lock_in,
  input  logic             osc_ready,
  output phase_e           phase,
  output logic             enter_stop,
  output logic             wake_start,
  output logic             wake_all_off,
  output logic             lock_back,
  output logic             osc_back,
  output logic             wake_armed
);
  phase_e           phase_q;
  logic             fwk_q;
  logic [CFG_W-1:0] cfg_q;
  logic             lock_wait_q;
  logic             osc_wait_q;
  logic             leave_stop;
  logic             lock_wait_n;
  logic             osc_wait_n;

  always_comb begin
    enter_stop   = (phase_q == PH_RUN) && stop_req;
    leave_stop   = (phase_q == PH_STOP) && !stop_req;
    wake_start   = leave_stop && fwk_q;
    wake_all_off = wake_start && (cfg_q == ALL_OFF);
    lock_back    = (phase_q == PH_WAKE) && lock_wait_q && pll_lock_in;
    osc_back     = (phase_q == PH_WAKE) && osc_wait_q && osc_ready;
    lock_wait_n  = lock_wait_q && !lock_back;
    osc_wait_n   = osc_wait_q && !osc_back;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_RUN;
      fwk_q       <= 1'b0;
      cfg_q       <= '0;
      lock_wait_q <= 1'b0;
      osc_wait_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          if (enter_stop) begin
            phase_q <= PH_STOP;
            fwk_q   <= fast_wake_en;
            cfg_q   <= stop_cfg;
          end
        end
        PH_STOP: begin
          if (leave_stop) begin
            if (fwk_q) begin
              phase_q     <= PH_WAKE;
              lock_wait_q <= 1'b1;
              osc_wait_q  <= (cfg_q == ALL_OFF);
            end else begin
              phase_q <= PH_RUN;
            end
          end
        end
        PH_WAKE: begin
          lock_wait_q <= lock_wait_n;
          osc_wait_q  <= osc_wait_n;
          if (!lock_wait_n && !osc_wait_n) phase_q <= PH_RUN;
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign phase      = phase_q;
  assign wake_armed = fwk_q;
endmodule

// File: rtl/clkstat_lock_flags.sv
module clkstat_lock_flags (
  input  logic clk,
  input  logic rst,
  input  logic pll_mode,
  input  logic run_active,
  input  logic enter_stop,
  input  logic wake_start,
  input  logic lock_back,
  input  logic pll_lock_in,
  output logic lock_live,
  output logic lock_sticky
);
  logic live_q;
  logic sticky_q;
  logic saved_q;
  logic lock_now;
  logic lock_drop;

  assign lock_now  = pll_mode && pll_lock_in;
  assign lock_drop = run_active && live_q && !lock_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
    end else begin
      live_q <= lock_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= 1'b0;
    end else if (enter_stop) begin
      saved_q <= sticky_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= pll_mode;
    end else if (wake_start) begin
      sticky_q <= 1'b0;
    end else if (lock_back) begin
      sticky_q <= saved_q;
    end else if (lock_drop) begin
      sticky_q <= 1'b0;
    end
  end

  assign lock_live   = live_q;
  assign lock_sticky = sticky_q;
endmodule

// File: rtl/clkstat_loc_flag.sv
module clkstat_loc_flag (
  input  logic clk,
  input  logic rst,
  input  logic pll_mode,
  input  logic run_active,
  input  logic loc_enable,
  input  logic loc_pulse,
  input  logic enter_stop,
  input  logic wake_all_off,
  input  logic osc_back,
  output logic clk_lost
);
  logic lost_q;
  logic saved_q;
  logic capture;

  assign capture = run_active && pll_mode && loc_enable && loc_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q <= 1'b0;
    end else if (enter_stop) begin
      saved_q <= lost_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lost_q <= 1'b0;
    end else if (wake_all_off) begin
      lost_q <= 1'b1;
    end else if (osc_back) begin
      lost_q <= saved_q;
    end else if (capture) begin
      lost_q <= 1'b1;
    end
  end

  assign clk_lost = lost_q;
endmodule

// File: rtl/clkstat_rd_port.sv
module clkstat_rd_port #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_strobe,
  input  logic [W-1:0] flags_in,
  output logic [W-1:0] rd_flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_flags <= '0;
    end else if (rd_strobe) begin
      rd_flags <= flags_in;
    end
  end
endmodule

// File: rtl/clkstat_flags.sv
module clkstat_flags
  import clkstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] clk_mode,
  input  logic              pll_lock_in,
  input  logic              loc_pulse,
  input  logic              loc_enable,
  input  logic              stop_req,
  input  logic [SEL_W-1:0]  stop_cfg,
  input  logic              fast_wake_en,
  input  logic              osc_ready,
  input  logic              rd_strobe,
  output logic              lock_live,
  output logic              lock_sticky,
  output logic              clk_lost,
  output logic [RD_W-1:0]   rd_flags
);
  phase_e          phase;
  logic            pll_mode;
  logic            run_active;
  logic            enter_stop;
  logic            wake_start;
  logic            wake_all_off;
  logic            lock_back;
  logic            osc_back;
  logic            wake_armed;
  logic [RD_W-1:0] flag_vec;

  assign pll_mode   = (clk_mode != MODE_EXTERNAL);
  assign run_active = (phase == PH_RUN);

  clkstat_seq #(.CFG_W(SEL_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .stop_req     (stop_req),
    .stop_cfg     (stop_cfg),
    .fast_wake_en (fast_wake_en),
    .pll_lock_in  (pll_lock_in),
    .osc_ready    (osc_ready),
    .phase        (phase),
    .enter_stop   (enter_stop),
    .wake_start   (wake_start),
    .wake_all_off (wake_all_off),
    .lock_back    (lock_back),
    .osc_back     (osc_back),
    .wake_armed   (wake_armed)
  );

  clkstat_lock_flags lock_i (
    .clk         (clk),
    .rst         (rst),
    .pll_mode    (pll_mode),
    .run_active  (run_active),
    .enter_stop  (enter_stop),
    .wake_start  (wake_start),
    .lock_back   (lock_back),
    .pll_lock_in (pll_lock_in),
    .lock_live   (lock_live),
    .lock_sticky (lock_sticky)
  );

  clkstat_loc_flag loc_i (
    .clk          (clk),
    .rst          (rst),
    .pll_mode     (pll_mode),
    .run_active   (run_active),
    .loc_enable   (loc_enable),
    .loc_pulse    (loc_pulse),
    .enter_stop   (enter_stop),
    .wake_all_off (wake_all_off),
    .osc_back     (osc_back),
    .clk_lost     (clk_lost)
  );

  always_comb begin
    flag_vec                = '0;
    flag_vec[RD_LIVE_BIT]   = lock_live;
    flag_vec[RD_STICKY_BIT] = lock_sticky;
    flag_vec[RD_LOST_BIT]   = clk_lost;
  end

  clkstat_rd_port #(.W(RD_W)) rd_i (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .flags_in  (flag_vec),
    .rd_flags  (rd_flags)
  );
endmodule

// File: rtl/clkstat_flags_chk.sv
module clkstat_flags_chk
  import clkstat_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] clk_mode,
  input logic              pll_lock_in,
  input logic              loc_enable,
  input logic              stop_req,
  input logic              rd_strobe,
  input logic              lock_live,
  input logic              lock_sticky,
  input logic              clk_lost,
  input logic [RD_W-1:0]   rd_flags,
  input phase_e            phase,
  input logic              wake_start,
  input logic              wake_all_off,
  input logic              wake_armed
);
  // R1: values just after reset release
  assert_reset_values_R1: assert property (@(posedge clk)
    $fell(rst) |-> (lock_sticky == (clk_mode != MODE_EXTERNAL)) && !clk_lost && !lock_live);

  assert_lock_drop_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && lock_live && !pll_lock_in) |=> !lock_sticky);

  assert_lost_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && clk_lost) |=> clk_lost);

  assert_lost_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && !loc_enable && !clk_lost) |=> !clk_lost);

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOP && (stop_req || !wake_armed)) |=> $stable(lock_sticky) && $stable(clk_lost));

  assert_wake_lock_forced_R8: assert property (@(posedge clk) disable iff (rst)
    wake_start |=> !lock_sticky);

  assert_wake_lost_forced_R9: assert property (@(posedge clk) disable iff (rst)
    wake_all_off |=> clk_lost);

  assert_read_capture_R10: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_flags == $past({lock_live, lock_sticky, clk_lost}));

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_flags));
endmodule

bind clkstat_flags clkstat_flags_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .clk_mode     (clk_mode),
  .pll_lock_in  (pll_lock_in),
  .loc_enable   (loc_enable),
  .stop_req     (stop_req),
  .rd_strobe    (rd_strobe),
  .lock_live    (lock_live),
  .lock_sticky  (lock_sticky),
  .clk_lost     (clk_lost),
  .rd_flags     (rd_flags),
  .phase        (phase),
  .wake_start   (wake_start),
  .wake_all_off (wake_all_off),
  .wake_armed   (wake_armed)
);

// File: tb/clkstat_flags_tb_top.sv
module clkstat_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] clk_mode = 2'b01;
  logic       pll_lock_in = 1'b0;
  logic       loc_pulse = 1'b0;
  logic       loc_enable = 1'b0;
  logic       stop_req = 1'b0;
  logic [1:0] stop_cfg = 2'b00;
  logic       fast_wake_en = 1'b0;
  logic       osc_ready = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       lock_live;
  logic       lock_sticky;
  logic       clk_lost;
  logic [2:0] rd_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkstat_flags dut_i (
    .clk          (clk),
    .rst          (rst),
    .clk_mode     (clk_mode),
    .pll_lock_in  (pll_lock_in),
    .loc_pulse    (loc_pulse),
    .loc_enable   (loc_enable),
    .stop_req     (stop_req),
    .stop_cfg     (stop_cfg),
    .fast_wake_en (fast_wake_en),
    .osc_ready    (osc_ready),
    .rd_strobe    (rd_strobe),
    .lock_live    (lock_live),
    .lock_sticky  (lock_sticky),
    .clk_lost     (clk_lost),
    .rd_flags     (rd_flags)
  );

  // vector: {lock_in, loc_pulse, loc_enable, exp_live, exp_sticky, exp_lost}
  localparam int NVEC = 7;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1_0_1_1_1_0,  // R2 live follows lock
    6'b1_1_0_1_1_0,  // R5 pulse ignored, enable low
    6'b1_1_1_1_1_1,  // R4 pulse captured
    6'b0_0_1_0_0_1,  // R3 lock drop clears sticky
    6'b1_0_1_1_0_1,  // R3 relock does not set sticky
    6'b1_0_0_1_0_1,  // R4 lost stays set
    6'b0_0_0_0_0_1   // R4 lost stays set
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] mode);
    clk_mode = mode;
    pll_lock_in = 1'b0; loc_pulse = 1'b0; loc_enable = 1'b0;
    stop_req = 1'b0; stop_cfg = 2'b00; fast_wake_en = 1'b0;
    osc_ready = 1'b0; rd_strobe = 1'b0;
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  function automatic logic [2:0] flags();
    return {lock_live, lock_sticky, clk_lost};
  endfunction

  initial begin
    @(negedge clk);
    // table walk, normal PLL mode
    do_reset(2'b01);
    check("R1 reset normal PLL", flags(), 3'b010);
    for (int i = 0; i < NVEC; i++) begin
      pll_lock_in = VEC[i][5];
      loc_pulse   = VEC[i][4];
      loc_enable  = VEC[i][3];
      step();
      loc_pulse = 1'b0;
      check($sformatf("R2/R3/R4/R5 vector %0d", i), flags(), VEC[i][2:0]);
    end

    // R1 external clock mode, R2 live stays low, R5 pulse ignored
    do_reset(2'b00);
    check("R1 reset external", flags(), 3'b000);
    pll_lock_in = 1'b1; loc_enable = 1'b1; loc_pulse = 1'b1;
    step(); loc_pulse = 1'b0;
    check("R2/R5 external ignores lock and pulse", flags(), 3'b000);

    // R1 one-to-one PLL mode
    do_reset(2'b10);
    check("R1 reset one-to-one", flags(), 3'b010);

    // R6 / R7 stop without fast wakeup
    do_reset(2'b01);
    pll_lock_in = 1'b1; step();
    stop_req = 1'b1; step();
    pll_lock_in = 1'b0; loc_enable = 1'b1; loc_pulse = 1'b1; step();
    loc_pulse = 1'b0; step();
    check("R6 flags held in stop", {lock_sticky, clk_lost}, 3'b010);
    stop_req = 1'b0; step(); step();
    check("R7 plain exit keeps flags", {lock_sticky, clk_lost}, 3'b010);

    // R8 fast wakeup, other stop kind
    do_reset(2'b01);
    pll_lock_in = 1'b1; step();
    fast_wake_en = 1'b1; stop_cfg = 2'b01; stop_req = 1'b1; step();
    pll_lock_in = 1'b0; step();
    stop_req = 1'b0; step();
    check("R8 sticky forced low after wake", {lock_sticky, clk_lost}, 3'b000);
    step(); step();
    check("R8 sticky low until relock", {lock_sticky, clk_lost}, 3'b000);
    pll_lock_in = 1'b1; step();
    check("R8/R9 restored, lost untouched", {lock_sticky, clk_lost}, 3'b010);

    // R9 fast wakeup from all-off stop, enable low
    do_reset(2'b01);
    pll_lock_in = 1'b1; step();
    fast_wake_en = 1'b1; stop_cfg = 2'b11; stop_req = 1'b1; step();
    pll_lock_in = 1'b0; step();
    stop_req = 1'b0; step();
    check("R9 lost forced high", {lock_sticky, clk_lost}, 3'b001);
    step();
    check("R9 lost held until oscillator", {lock_sticky, clk_lost}, 3'b001);
    osc_ready = 1'b1; step();
    check("R9 lost restored", {lock_sticky, clk_lost}, 3'b000);
    pll_lock_in = 1'b1; step();
    check("R8 sticky restored", {lock_sticky, clk_lost}, 3'b010);

    // R10 read capture
    do_reset(2'b01);
    pll_lock_in = 1'b1; loc_enable = 1'b1; step();
    rd_strobe = 1'b1; loc_pulse = 1'b1; step();
    rd_strobe = 1'b0; loc_pulse = 1'b0;
    check("R10 read returns pre-event value", rd_flags, 3'b110);
    check("R4 event still captured", flags(), 3'b111);
    step();
    check("R10 read holds", rd_flags, 3'b110);
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    check("R10 second read", rd_flags, 3'b111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule